// File: doc/BRIEF.md
# Ordering-Table Clear DMA Engine

This engine fills a region of memory with a downward-linked list of 32-bit words and touches no peripheral. Software loads a top address and an entry count, then writes a control word with the go bit set. When that control word matches the one accepted command, the engine walks downward one word per accepted memory write. Each word holds the low 24 bits of the address of the word just below it. The lowest word gets an all-ones 24-bit terminator instead.

When the walk ends, or at once for an unknown command or an empty count, the go bit in the control register drops and a one-cycle interrupt pulse goes out. A graphics front end can then fill the cleared table, knowing every slot already chains to the end marker. The address register moves with the walk, so after completion it holds the address one step below the last word written.

Top module: `ot_clear_dma`

## Requirements
- R1: After reset, busy, irq and mem_valid are 0 and both register outputs read 0. Register selects are 0 for the top address, 1 for the entry count (low 16 bits) and 2 for the control word. A control write with bit 24 clear while idle stores the word and starts nothing. A control write with bit 24 set while idle raises busy from the next cycle.
- R2: Only the exact control word 0x11000002 builds a list. Any other word with bit 24 set makes no memory write and completes as in R7.
- R3: For a count of N, exactly N writes are issued. Write k (k = 0..N-1) targets the top address minus 4·k, wrapping modulo 2^32, in strictly descending order.
- R4: Every entry except the last holds (its own address − 4) & 0xFFFFFF, with bits 31..24 zero.
- R5: The last entry, at the lowest address, holds 0x00FFFFFF.
- R6: A write is transferred on each cycle where mem_valid and mem_ready are both 1. While mem_ready is 0, mem_valid, mem_addr and mem_data hold their values.
- R7: In the cycle after the last accepted write, busy stays 1. One cycle later busy falls, bit 24 of the control output is 0 with all other bits kept, and irq is 1 for exactly that one cycle.
- R8: A count of zero with the build command makes no write and completes as in R7.
- R9: The address output drops by 4 after each accepted write and ends at the top address minus 4·N.
- R10: Writes to any register while busy is 1 are ignored. The write count, the addresses, the control output and the final address output are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 top address, 1 count, 2 control |
| reg_wdata | input | 32 | Register write data |
| mem_valid | output | 1 | Memory write offered |
| mem_ready | input | 1 | Memory accepts the offered write |
| mem_addr | output | 32 | Byte address of the offered write |
| mem_data | output | 32 | Link or terminator word |
| irq | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Channel active |
| ctrl_value | output | 32 | Current control register |
| addr_value | output | 32 | Current address register |

## Verification
A wrong address register shows up on mem_addr and addr_value in the very cycle of the next offered write. The bench compares both against a queue of expected writes every clock, so the fault appears at once. A count that is off by one moves the terminator to the wrong word or changes the number of writes, and the final word of the run shows it. A sequencer that skips or lingers in its finishing step moves the busy fall and the irq pulse by a cycle, and the per-clock comparison with the behavioural model catches that. Stalled handshakes, an address that wraps below zero and mid-run register writes are driven so that lost holds, bad masking and writes that should have been ignored also appear at the ports.

// File: rtl/ot_dma_pkg.sv
package ot_dma_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned GO_BIT     = 24;
  localparam int unsigned STEP_BYTES = 4;
  localparam logic [WORD_W-1:0] BUILD_CMD = 32'h1100_0002;

  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ot_state_e;
endpackage

// File: rtl/ot_seq.sv
module ot_seq
  import ot_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      cmd_ok_i,
  input  logic      cnt_zero_i,
  input  logic      fire_i,
  input  logic      last_i,
  output ot_state_e state_o,
  output logic      busy_o,
  output logic      finish_o
);
  ot_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = (cmd_ok_i && !cnt_zero_i) ? ST_RUN : ST_FIN;
        end
      end
      ST_RUN: begin
        if (fire_i && last_i) begin
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o  = state_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign finish_o = (state_q == ST_FIN);

  // R7: the finishing step lasts exactly one cycle
  a_r7_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |=> (state_q == ST_IDLE));

  // R8: a start on an empty count skips the walk
  a_r8_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (state_q == ST_IDLE) && cnt_zero_i) |=> (state_q == ST_FIN));

  // R2: a start with a foreign command skips the walk
  a_r2_bad_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (state_q == ST_IDLE) && !cmd_ok_i) |=> (state_q == ST_FIN));
endmodule

// File: rtl/ot_walker.sv
module ot_walker
  import ot_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LINK_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              count_we_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              fire_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] link_o,
  output logic              last_o,
  output logic              cnt_zero_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);
  localparam logic [WORD_W-1:0] TERM = WORD_W'({LINK_W{1'b1}});

  logic [ADDR_W-1:0] addr_q, addr_d, next_addr;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              addr_en, cnt_en;

  assign next_addr = addr_q - STEP;

  always_comb begin
    addr_en = fire_i | (base_we_i & ~busy_i);
    addr_d  = fire_i ? next_addr : base_i;
    cnt_en  = fire_i | (count_we_i & ~busy_i);
    cnt_d   = fire_i ? (cnt_q - ONE) : count_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign last_o     = (cnt_q == ONE);
  assign cnt_zero_o = (cnt_q == '0);
  assign addr_o     = addr_q;
  assign link_o     = last_o ? TERM : WORD_W'(next_addr[LINK_W-1:0]);

  // R9: each accepted write moves the pointer one word down
  a_r9_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (addr_q == $past(addr_q) - STEP));

  // R10: while busy only accepted writes change the pointer and the count
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !fire_i) |=> ($stable(addr_q) && $stable(cnt_q)));
endmodule

// File: rtl/ot_ctrl_reg.sv
module ot_ctrl_reg
  import ot_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              finish_i,
  output logic [WORD_W-1:0] ctrl_o
);
  localparam logic [WORD_W-1:0] GO_MASK = WORD_W'(1) << GO_BIT;

  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;

  always_comb begin
    ctrl_en = we_i | finish_i;
    ctrl_d  = finish_i ? (ctrl_q & ~GO_MASK) : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;

  // R7: completion drops the go bit
  a_r7_go_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i |=> !ctrl_q[GO_BIT]);

  // R10: without an accepted write or a completion the word is kept
  a_r10_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !finish_i) |=> $stable(ctrl_q));
endmodule

// File: rtl/ot_clear_dma.sv
module ot_clear_dma
  import ot_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LINK_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic              irq,
  output logic              busy,
  output logic [WORD_W-1:0] ctrl_value,
  output logic [ADDR_W-1:0] addr_value
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  ot_state_e         state;
  logic              finish, fire, last, cnt_zero, start, cmd_ok;
  logic              base_we, count_we, ctrl_we;
  logic [ADDR_W-1:0] ptr;
  logic [WORD_W-1:0] link;
  logic              irq_q;

  always_comb begin
    base_we  = reg_we && (reg_sel == SEL_BASE);
    count_we = reg_we && (reg_sel == SEL_COUNT);
    ctrl_we  = reg_we && (reg_sel == SEL_CTRL) && !busy;
    start    = ctrl_we && reg_wdata[GO_BIT];
    cmd_ok   = (reg_wdata == BUILD_CMD);
    fire     = mem_valid && mem_ready;
  end

  ot_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start),
    .cmd_ok_i   (cmd_ok),
    .cnt_zero_i (cnt_zero),
    .fire_i     (fire),
    .last_i     (last),
    .state_o    (state),
    .busy_o     (busy),
    .finish_o   (finish)
  );

  ot_walker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .LINK_W (LINK_W)
  ) i_walker (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .busy_i     (busy),
    .base_we_i  (base_we),
    .base_i     (reg_wdata[ADDR_W-1:0]),
    .count_we_i (count_we),
    .count_i    (reg_wdata[CNT_W-1:0]),
    .fire_i     (fire),
    .addr_o     (ptr),
    .link_o     (link),
    .last_o     (last),
    .cnt_zero_o (cnt_zero)
  );

  ot_ctrl_reg i_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we_i     (ctrl_we),
    .wdata_i  (reg_wdata),
    .finish_i (finish),
    .ctrl_o   (ctrl_value)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= finish;
    end
  end

  assign mem_valid  = (state == ST_RUN);
  assign mem_addr   = ptr;
  assign mem_data   = link;
  assign addr_value = ptr;
  assign irq        = irq_q;

  // R6: a stalled offer keeps valid, address and data
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R7: the interrupt is a single pulse seen with the channel idle
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |=> !irq);
  a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (!busy && !ctrl_value[GO_BIT]));

  // R2: nothing is offered outside an active channel
  a_r2_valid_busy: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_valid |-> busy);

  // R4: a link word never carries bits above the link width
  a_r4_link_width: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_valid |-> (mem_data[WORD_W-1:LINK_W] == '0));
endmodule

// File: tb/test_ot_clear_dma.sv
`timescale 1ns/1ps
module test_ot_clear_dma;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        mem_valid, mem_ready;
  logic [31:0] mem_addr, mem_data;
  logic        irq, busy;
  logic [31:0] ctrl_value, addr_value;

  always #2.5 clk = ~clk;

  ot_clear_dma i_ot_clear_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .irq(irq), .busy(busy), .ctrl_value(ctrl_value), .addr_value(addr_value)
  );

  int n_chk = 0;
  int n_err = 0;
  int n_fire = 0;
  int cycles = 0;
  int stall = 0;
  bit done = 0;

  // behavioural model
  int          m_phase;
  logic [31:0] m_base, m_ctrl;
  int          m_cnt;
  logic        m_irq;
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_base = 0; m_cnt = 0; m_ctrl = 0; m_irq = 0;
      q_addr.delete(); q_data.delete();
    end else begin
      m_irq = 0;
      case (m_phase)
        0: if (reg_we) begin
          if (reg_sel == 2'd0) m_base = reg_wdata;
          else if (reg_sel == 2'd1) m_cnt = int'(reg_wdata[15:0]);
          else if (reg_sel == 2'd2) begin
            m_ctrl = reg_wdata;
            if (reg_wdata[24]) begin
              if (reg_wdata == 32'h1100_0002 && m_cnt != 0) begin
                m_phase = 1;
                for (int k = 0; k < m_cnt; k++) begin
                  logic [31:0] a;
                  a = m_base - 32'(4 * k);
                  q_addr.push_back(a);
                  q_data.push_back((k == m_cnt - 1) ? 32'h00FF_FFFF : ((a - 32'd4) & 32'h00FF_FFFF));
                end
              end else begin
                m_phase = 2;
              end
            end
          end
        end
        1: if (mem_ready) begin
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
          m_base = m_base - 32'd4;
          m_cnt--;
          if (m_cnt == 0) m_phase = 2;
        end
        default: begin
          m_phase = 0;
          m_ctrl[24] = 1'b0;
          m_irq = 1;
        end
      endcase
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy === (m_phase != 0), "R1", "busy", 32'(busy), 32'(m_phase != 0));
      chk(irq === m_irq, "R7", "irq", 32'(irq), 32'(m_irq));
      chk(mem_valid === (m_phase == 1), "R6", "mem_valid", 32'(mem_valid), 32'(m_phase == 1));
      chk(ctrl_value === m_ctrl, "R7", "ctrl_value", ctrl_value, m_ctrl);
      chk(addr_value === m_base, "R9", "addr_value", addr_value, m_base);
      if (mem_valid && q_addr.size() > 0) begin
        chk(mem_addr === q_addr[0], "R3", "mem_addr", mem_addr, q_addr[0]);
        if (q_addr.size() == 1)
          chk(mem_data === q_data[0], "R5", "terminator", mem_data, q_data[0]);
        else
          chk(mem_data === q_data[0], "R4", "link", mem_data, q_data[0]);
      end
      if (mem_valid && mem_ready) n_fire++;
    end
  end

  always @(posedge clk) begin
    #1;
    if (stall == 1) mem_ready = ($urandom_range(0, 2) != 0);
    else if (stall == 2) mem_ready = 1'b0;
    else mem_ready = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    step();
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && m_phase != 0; i++) step();
    step(); step();
  endtask

  task automatic run(input string req, input logic [31:0] base, input int n,
                     input logic [31:0] ctrl, input int mode, input int exp_w);
    int f0;
    stall = mode;
    wr(2'd0, base);
    wr(2'd1, 32'(n));
    f0 = n_fire;
    wr(2'd2, ctrl);
    wait_idle();
    chk(n_fire - f0 == exp_w, req, "write count", 32'(n_fire - f0), 32'(exp_w));
    chk(addr_value === base - 32'(4 * exp_w), "R9", "final address", addr_value, base - 32'(4 * exp_w));
    chk(ctrl_value === (ctrl & ~32'h0100_0000), "R7", "final control", ctrl_value, ctrl & ~32'h0100_0000);
    stall = 0;
  endtask

  initial begin
    int f0;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0; mem_ready = 1'b1;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1: reset state
    chk(busy === 1'b0 && irq === 1'b0 && mem_valid === 1'b0, "R1", "reset flags",
        {29'd0, busy, irq, mem_valid}, 32'd0);
    chk(ctrl_value === 32'd0, "R1", "reset control", ctrl_value, 32'd0);
    chk(addr_value === 32'd0, "R1", "reset address", addr_value, 32'd0);

    // R1: control write without the go bit starts nothing
    wr(2'd1, 32'd3);
    f0 = n_fire;
    wr(2'd2, 32'h1000_0002);
    step(); step();
    chk(busy === 1'b0, "R1", "no start without go bit", 32'(busy), 32'd0);
    chk(ctrl_value === 32'h1000_0002, "R1", "stored control", ctrl_value, 32'h1000_0002);
    chk(n_fire == f0, "R1", "no writes", 32'(n_fire - f0), 32'd0);

    run("R3", 32'h0000_0100, 5, 32'h1100_0002, 0, 5);
    run("R5", 32'h0000_2000, 1, 32'h1100_0002, 0, 1);
    run("R6", 32'h8000_0010, 6, 32'h1100_0002, 1, 6);     // R4 masking of high bits
    run("R2", 32'h0000_0300, 4, 32'h1100_0003, 0, 0);
    run("R2", 32'h0000_0300, 4, 32'h0100_0201, 1, 0);
    run("R8", 32'h0000_0500, 0, 32'h1100_0002, 0, 0);
    run("R3", 32'h0000_0008, 4, 32'h1100_0002, 1, 4);     // wraps below zero

    // R10: register writes during a stalled run are ignored
    stall = 2;
    wr(2'd0, 32'h0000_0400);
    wr(2'd1, 32'd8);
    f0 = n_fire;
    wr(2'd2, 32'h1100_0002);
    step();
    wr(2'd0, 32'h0000_0999);
    wr(2'd1, 32'd50);
    wr(2'd2, 32'h0000_0000);
    chk(ctrl_value === 32'h1100_0002, "R10", "control during run", ctrl_value, 32'h1100_0002);
    stall = 1;
    wait_idle();
    chk(n_fire - f0 == 8, "R10", "write count", 32'(n_fire - f0), 32'd8);
    chk(addr_value === 32'h0000_03E0, "R10", "final address", addr_value, 32'h0000_03E0);
    chk(ctrl_value === 32'h1000_0002, "R10", "final control", ctrl_value, 32'h1000_0002);
    stall = 0;

    repeat (3) step();
    report();
  end
endmodule